// File: doc/BRIEF.md
# I2C Write-Only Register Target with Auto-Incrementing Pointer

This block is an I2C target that connects a small bank of 8-bit registers to a two-wire bus. It samples SCL and SDA with the system clock and finds the bus conditions. It answers one fixed 7-bit device address, and only for write transfers. Inside a transfer, the first byte after the address is a command byte that sets a register pointer. Every later byte is written to the register that the pointer selects, and the pointer then moves on to the next register.

The block drives the bus through a pull-down enable for an external open-drain SDA pad. It delivers writes on a simple port that carries an address, a data byte and a one-cycle strobe. The system clock must be at least eight times faster than SCL, so that each SCL phase lasts longer than the synchronizer latency.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset, `sda_pd_o` and `wr_en_o` are both 0, and no write takes place before a valid transfer.
- R2: A START (SDA falls while SCL is high) begins address reception. A repeated START in the middle of a transfer is handled the same way, and it recovers a transfer that was being ignored.
- R3: Each byte is received most significant bit first, sampled on SCL rising edges. A ninth clock follows it for the acknowledge.
- R4: To acknowledge, the block pulls SDA low from the SCL fall after bit 8 until the SCL fall after the acknowledge clock. It never drives SDA during the eight data clocks.
- R5: An address byte of 7'b1100100 followed by R/W = 0 (byte value 8'hC8) is acknowledged.
- R6: Any other address, or the matching address with R/W = 1, is not acknowledged. All later bytes are then neither acknowledged nor written until the next START or STOP.
- R7: The byte after a matched address is acknowledged and loads the pointer with its value modulo NUM_REGS. It causes no write.
- R8: Every byte after the command byte is acknowledged and produces a one-cycle `wr_en_o` pulse. With the pulse, `wr_addr_o` carries the pointer and `wr_data_o` carries the byte.
- R9: After each write the pointer advances by one and wraps from NUM_REGS-1 to 0.
- R10: A STOP (SDA rises while SCL is high) returns the block to idle and leaves the pointer unchanged. Bytes clocked after a STOP without a new START get no acknowledge and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_pd_o | output | 1 | SDA pull-down enable (1 = drive low) |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | $clog2(NUM_REGS) | Register index of the write |
| wr_data_o | output | 8 | Data byte of the write |

## Verification
The hardest cases to reach from the pins are the rare pointer states: the wrap from the last register to register 0, and command values above NUM_REGS that must be reduced. Recovery from an ignored transfer by a repeated START is also hard to reach. The bench gets to the pointer cases with a sweep of command bytes, each followed by a burst of three data bytes, so many of those bursts cross the top of the register range. It gets to the recovery case with a mismatched address followed at once by a repeated START to the correct address. A separate sweep sends all 128 addresses, each followed by two bytes, so that the no-acknowledge and no-write behaviour is checked for every wrong address.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  // conditions: SDA edge with SCL high on both samples
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2c_regwr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_lvl_i,
  input  logic  sda_i,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  logic  ack_i,
  output logic  byte_done_o,
  output byte_t byte_o,
  output logic  sda_pd_o
);
  logic [3:0] bit_cnt;
  byte_t      shreg;
  logic       ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      shreg   <= '0;
      ack_q   <= 1'b0;
    end else if (start_i || stop_i) begin
      bit_cnt <= '0;
      ack_q   <= 1'b0;
    end else if (scl_rise_i) begin
      if (bit_cnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_i};
      if (bit_cnt <= 4'd8) bit_cnt <= bit_cnt + 4'd1;
    end else if (scl_fall_i) begin
      if (bit_cnt == 4'd8) ack_q <= ack_i;
      if (bit_cnt == 4'd9) begin
        ack_q   <= 1'b0;
        bit_cnt <= '0;
      end
    end
  end

  assign byte_done_o = scl_fall_i && (bit_cnt == 4'd8);
  assign byte_o      = shreg;
  assign sda_pd_o    = ack_q;

  p_ack_edge_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_lvl_i);
  p_ack_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pd_o |-> (bit_cnt == 4'd8 || bit_cnt == 4'd9));
endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100100,
  parameter int         NUM_REGS = 16,
  parameter int         PW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_done_i,
  input  byte_t         byte_i,
  output logic          ack_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output byte_t         wr_data_o
);
  phase_e        phase_q;
  logic [PW-1:0] ptr_q;
  logic          addr_hit;

  function automatic logic [PW-1:0] reduce_idx(input byte_t b);
    int unsigned v;
    v = int'(b) % NUM_REGS;
    return PW'(v);
  endfunction

  function automatic logic [PW-1:0] next_idx(input logic [PW-1:0] p);
    return (p == PW'(NUM_REGS - 1)) ? '0 : p + PW'(1);
  endfunction

  assign addr_hit = (byte_i == {DEV_ADDR, 1'b0});
  assign ack_o = byte_done_i &&
                 ((phase_q == PH_ADDR && addr_hit) || phase_q == PH_CMD || phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      ptr_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_ADDR;
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
      end else if (byte_done_i) begin
        unique case (phase_q)
          PH_ADDR: phase_q <= addr_hit ? PH_CMD : PH_SKIP;
          PH_CMD: begin
            ptr_q   <= reduce_idx(byte_i);
            phase_q <= PH_DATA;
          end
          PH_DATA: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= byte_i;
            ptr_q     <= next_idx(ptr_q);
          end
          default: ;
        endcase
      end
    end
  end

  p_start_to_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> phase_q == PH_ADDR);
  p_skip_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_SKIP |-> !ack_o && !wr_en_o);
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  p_ptr_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ptr_q == next_idx(wr_addr_o));
  p_stop_keeps_ptr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(ptr_q) && phase_q == PH_IDLE);
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1100100,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  logic  scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic  byte_done, ack_req;
  byte_t rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_byte_rx u_rx (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .ack_i(ack_req),
    .byte_done_o(byte_done), .byte_o(rx_byte),
    .sda_pd_o
  );

  i2c_frame_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PW(PW)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(start_c), .stop_i(stop_c),
    .byte_done_i(byte_done), .byte_i(rx_byte),
    .ack_o(ack_req),
    .wr_en_o, .wr_addr_o, .wr_data_o
  );
endmodule

// File: tb/sim_i2c_regwr_target.sv
module sim_i2c_regwr_target;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pd, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pd;

  i2c_regwr_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pd_o(sda_pd), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int nchk = 0, nerr = 0;
  int wr_cnt = 0;
  int log_a [64];
  int log_d [64];

  always @(negedge clk) begin
    if (rst_n && wr_en === 1'b1) begin
      log_a[wr_cnt % 64] = int'(wr_addr);
      log_d[wr_cnt % 64] = int'(wr_data);
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tq;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tq; scl_m = 1'b1; tq; sda_m = 1'b0; tq; scl_m = 1'b0; tq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tq; scl_m = 1'b1; tq; sda_m = 1'b1; tq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit drove);
    drove = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tq; scl_m = 1'b1; tq;
      if (sda_pd !== 1'b0) drove = 1'b1;
      tq; scl_m = 1'b0; tq;
    end
    sda_m = 1'b1; tq; scl_m = 1'b1; tq;
    ack = (sda_line === 1'b0);
    tq; scl_m = 1'b0; tq;
  endtask

  task automatic check_write(input int idx, input int ea, input int ed, input string tag);
    chk(log_a[idx % 64] == ea, {tag, " write address"}, log_a[idx % 64], ea);
    chk(log_d[idx % 64] == ed, {tag, " write data"}, log_d[idx % 64], ed);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    report();
    $finish;
  end

  initial begin
    bit ack, drv;
    int base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    tq;
    // R1 reset state
    chk(sda_pd === 1'b0, "R1 sda_pd_o after reset", int'(sda_pd), 0);
    chk(wr_en === 1'b0, "R1 wr_en_o after reset", int'(wr_en), 0);
    chk(wr_cnt == 0, "R1 no write after reset", wr_cnt, 0);

    // R5/R6 address sweep, then command and data byte
    for (int a = 0; a < 128; a++) begin
      bit hit;
      logic [7:0] cmd, dat;
      hit  = (a == 7'h64);
      cmd  = 8'(a * 3);
      dat  = 8'(a) ^ 8'hA5;
      base = wr_cnt;
      bus_start();
      send_byte({7'(a), 1'b0}, ack, drv);
      chk(ack == hit, hit ? "R5 address ack" : "R6 address nack", int'(ack), int'(hit));
      chk(!drv, "R4 no drive during address bits", int'(drv), 0);
      chk(sda_pd === 1'b0, "R4 release after ack clock", int'(sda_pd), 0);
      send_byte(cmd, ack, drv);
      chk(ack == hit, hit ? "R7 command ack" : "R6 command ignored", int'(ack), int'(hit));
      send_byte(dat, ack, drv);
      chk(ack == hit, hit ? "R8 data ack" : "R6 data ignored", int'(ack), int'(hit));
      bus_stop();
      chk(wr_cnt == base + (hit ? 1 : 0), hit ? "R8 write count" : "R6 no write", wr_cnt - base, hit ? 1 : 0);
      if (hit) check_write(base, int'(cmd) % NREG, int'(dat), "R8 R3");
    end

    // R6 matching address with read bit
    base = wr_cnt;
    bus_start();
    send_byte(8'hC9, ack, drv);
    chk(!ack, "R6 read bit nack", int'(ack), 0);
    send_byte(8'h02, ack, drv);
    chk(!ack, "R6 byte after read nack", int'(ack), 0);
    send_byte(8'h77, ack, drv);
    chk(!ack, "R6 byte after read nack", int'(ack), 0);
    bus_stop();
    chk(wr_cnt == base, "R6 no write after read address", wr_cnt - base, 0);

    // R10 bytes after STOP without START
    scl_m = 1'b0; tq;
    send_byte(8'h12, ack, drv);
    chk(!ack, "R10 idle byte nack", int'(ack), 0);
    send_byte(8'h34, ack, drv);
    chk(!ack, "R10 idle byte nack", int'(ack), 0);
    chk(wr_cnt == base, "R10 no write while idle", wr_cnt - base, 0);

    // R2 repeated START recovery and R9 wrap
    base = wr_cnt;
    bus_start();
    send_byte(8'hCA, ack, drv);
    chk(!ack, "R6 wrong address nack", int'(ack), 0);
    bus_start();
    send_byte(8'hC8, ack, drv);
    chk(ack, "R2 repeated START address ack", int'(ack), 1);
    send_byte(8'h03, ack, drv);
    chk(ack, "R7 command ack", int'(ack), 1);
    send_byte(8'h11, ack, drv);
    chk(ack, "R8 data ack", int'(ack), 1);
    bus_start();
    send_byte(8'hC8, ack, drv);
    chk(ack, "R2 second repeated START ack", int'(ack), 1);
    send_byte(8'h0E, ack, drv);
    send_byte(8'h22, ack, drv);
    send_byte(8'h33, ack, drv);
    send_byte(8'h44, ack, drv);
    chk(ack, "R9 ack after wrap", int'(ack), 1);
    bus_stop();
    chk(wr_cnt == base + 4, "R2 write count", wr_cnt - base, 4);
    check_write(base,     3,  8'h11, "R2");
    check_write(base + 1, 14, 8'h22, "R2");
    check_write(base + 2, 15, 8'h33, "R9");
    check_write(base + 3, 0,  8'h44, "R9 wrap");

    // R7/R9 command sweep with three-byte bursts
    for (int k = 0; k < 24; k++) begin
      logic [7:0] c;
      c = 8'(k * 11);
      base = wr_cnt;
      bus_start();
      send_byte(8'hC8, ack, drv);
      send_byte(c, ack, drv);
      chk(ack, "R7 command ack", int'(ack), 1);
      chk(wr_cnt == base, "R7 command causes no write", wr_cnt - base, 0);
      for (int j = 0; j < 3; j++) begin
        send_byte(8'(c + 8'(17 * j + 1)), ack, drv);
        chk(ack, "R8 burst data ack", int'(ack), 1);
        chk(!drv, "R4 no drive during data bits", int'(drv), 0);
      end
      bus_stop();
      chk(wr_cnt == base + 3, "R8 burst write count", wr_cnt - base, 3);
      for (int j = 0; j < 3; j++)
        check_write(base + j, ((int'(c) % NREG) + j) % NREG, int'(8'(c + 8'(17 * j + 1))), "R9 R3");
    end

    report();
    $finish;
  end
endmodule